// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

This block is a multi-channel pulse-width modulator. One shared counter runs in either edge-aligned (saw-tooth) or center-aligned (triangle) fashion. Each channel compares the count with its own threshold to form a reference waveform. A dead-band stage then turns that reference into two opposed pins: a main output and a complementary output. Whenever the reference changes, the output that is about to become active is held back for a programmable number of clocks, so the two pins of a channel are never active together.

Software sets the block up through a simple write-only register port: one write strobe, an address and a data word. The period and the thresholds are double-buffered. A write lands in a shadow register and reaches the working copy only at the counter's update point, or at once while the counter is stopped. The dead band is the product of an 8-bit piecewise code and a division factor of 1, 2 or 4. Each channel has an enable bit, which gates both of its pins together, and a polarity bit, which inverts both of its pins together.

Top module: `cpwm_deadband`

## Requirements
- R1: After reset the counter is stopped at 0 and every configuration register reads as 0, so both pins of every channel drive 0.
- R2: Control register (address 0): bit0 = run, bit1 = center-aligned, bits[3:2] = dead-band division. With run=1 and center=0 the counter steps 0,1,…,P and then returns to 0, where P is the period register (address 1), so one period lasts P+1 clocks. With run=0 the counter is held at 0.
- R3: The reference of channel n is active while count < C[n], where C[n] is the CNT_W+1-bit threshold at address 8+n. C[n]=0 keeps the main side inactive for good, and any C[n] ≥ P+1 keeps it active for good; both ends are legal.
- R4: Writes to the period and threshold registers go to shadow copies. The working copies take them at the update point and at no other time while running. The update point is the wrap P→0 in edge mode and the arrival at 0 while descending in center mode. While run=0 the working copies follow the shadows on every clock.
- R5: With run=1 and center=1 the counter climbs from 0 to P and then descends to 0, so a full cycle lasts 2·P clocks (P ≥ 1).
- R6: The pins lag the reference by one clock. When the reference rises, the complementary side goes inactive on the next clock and the main side goes active DT+1 clocks after the change. When the reference falls, the same happens with the two sides swapped.
- R7: The dead-band length DT in clocks comes from the code at address 2. Codes 0–127 give the code itself. Codes 128–191 give 2·(64+code[5:0]). Codes 192–223 give 8·(32+code[4:0]). Codes 224–255 give 16·(32+code[4:0]). The result is then multiplied by 1, 2, 4 or 4 for division field values 00, 01, 10 and 11.
- R8: If the reference stays in one state for L ≤ DT clocks, the side that would have become active stays inactive for that whole interval. The main and complementary sides are never active at the same time.
- R9: Polarity register (address 4): bit n = 1 inverts both pins of channel n, so the inactive level becomes 1.
- R10: Enable register (address 3): bit n = 0 forces both pins of channel n to their inactive level (equal to the polarity bit). Bit n = 1 releases both pins together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | CNT_W+1 | Configuration write data |
| pwm_main | output | NUM_CH | Main output of each channel |
| pwm_comp | output | NUM_CH | Complementary output of each channel |

## Verification
The bench drives thresholds of 0 and above the period. A design with an off-by-one comparator would then show a one-clock glitch at 0% or 100% duty. It rewrites the period and the thresholds in the middle of a period; a design without shadow registers would change the duty inside that period. It runs dead-band codes from all four ranges and all division settings against pulses that are longer or shorter than the band. A wrong decode shows up as misplaced rising edges, and a missing reload on a short interval shows up as a sliver pulse on the wrong side. Center-aligned runs with P=5 and P=1 test the turn-around points and the update position; an off-by-one there stretches or shifts the triangle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam int ADDR_W = 4;
  localparam int DT_W   = 12;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 4'h1;
  localparam logic [ADDR_W-1:0] A_DTCODE = 4'h2;
  localparam logic [ADDR_W-1:0] A_OUTEN  = 4'h3;
  localparam logic [ADDR_W-1:0] A_POLINV = 4'h4;
  localparam int                A_CMP0   = 8;

  // Dead-band length in timer clocks from the 8-bit code and division field.
  function automatic logic [DT_W-1:0] dt_cycles(input logic [7:0] code,
                                                input logic [1:0] div);
    logic [DT_W-1:0] base;
    if (!code[7])      base = DT_W'(code);
    else if (!code[6]) base = (DT_W'(code[5:0]) + DT_W'(64)) << 1;
    else if (!code[5]) base = (DT_W'(code[4:0]) + DT_W'(32)) << 3;
    else               base = (DT_W'(code[4:0]) + DT_W'(32)) << 4;
    case (div)
      2'b00:   return base;
      2'b01:   return base << 1;
      default: return base << 2;
    endcase
  endfunction

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             center,
  input  logic [CNT_W-1:0] arr_sh,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, arr_q, arr_d, down_t;
  logic             up_q, up_d, reload;

  always_comb begin
    cnt_d  = cnt_q;
    up_d   = up_q;
    reload = 1'b0;
    down_t = (cnt_q == '0) ? '0 : cnt_q - ONE;
    if (!run) begin
      cnt_d  = '0;
      up_d   = 1'b1;
      reload = 1'b1;
    end else if (!center) begin
      up_d = 1'b1;
      if (cnt_q >= arr_q) begin
        cnt_d  = '0;
        reload = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (up_q && (cnt_q < arr_q)) begin
      cnt_d = cnt_q + ONE;
    end else begin
      cnt_d  = down_t;
      up_d   = (down_t == '0);
      reload = (down_t == '0);
    end
    arr_d = reload ? arr_sh : arr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      arr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      arr_q <= arr_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload;

  assert_cnt_le_period_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= arr_q);

  assert_edge_wrap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !center && cnt_q == arr_q) |=> (cnt_q == '0));

  assert_center_turn_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && center && up_q && cnt_q == arr_q && arr_q != '0)
      |=> (!run || !center || cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
  parameter int CNT_W = 8,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CMP_W-1:0] cmp_data,
  input  logic             reload,
  input  logic [CNT_W-1:0] cnt,
  output logic             ref_o
);

  logic [CMP_W-1:0] sh_q, sh_d, act_q, act_d;

  always_comb begin
    sh_d  = cmp_wr ? cmp_data : sh_q;
    act_d = reload ? sh_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign ref_o = ({1'b0, cnt} < act_q);

  assert_cmp_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(reload));

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_cyc,
  input  logic            en,
  input  logic            pol,
  output logic            pin_main,
  output logic            pin_comp
);

  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic            ref_q;
  logic [DT_W-1:0] tmr_q, tmr_d;
  logic            chg, settled, act_main, act_comp;

  always_comb begin
    chg = ref_i ^ ref_q;
    if (chg)              tmr_d = dt_cyc;
    else if (tmr_q != '0) tmr_d = tmr_q - ONE;
    else                  tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      tmr_q <= '0;
    end else begin
      ref_q <= ref_i;
      tmr_q <= tmr_d;
    end
  end

  assign settled  = (tmr_q == '0);
  assign act_main = ref_q & settled;
  assign act_comp = ~ref_q & settled;
  assign pin_main = (en & act_main) ^ pol;
  assign pin_comp = (en & act_comp) ^ pol;

  assert_no_overlap_main_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (act_main && dt_cyc != '0) |=> !act_comp);

  assert_no_overlap_comp_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (act_comp && dt_cyc != '0) |=> !act_main);

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
  import cpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [CMP_W-1:0]  cfg_wdata,
  output logic [NUM_CH-1:0] pwm_main,
  output logic [NUM_CH-1:0] pwm_comp
);

  logic              run_q, run_d, center_q, center_d;
  logic [1:0]        div_q, div_d;
  logic [7:0]        code_q, code_d;
  logic [NUM_CH-1:0] en_q, en_d, pol_q, pol_d;
  logic [CNT_W-1:0]  arr_q, arr_d;
  logic [CNT_W-1:0]  cnt;
  logic              reload;
  logic [DT_W-1:0]   dt_cyc;
  logic [NUM_CH-1:0] ref_w;

  always_comb begin
    run_d    = run_q;
    center_d = center_q;
    div_d    = div_q;
    code_d   = code_q;
    en_d     = en_q;
    pol_d    = pol_q;
    arr_d    = arr_q;
    if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: begin
          run_d    = cfg_wdata[0];
          center_d = cfg_wdata[1];
          div_d    = cfg_wdata[3:2];
        end
        A_PERIOD: arr_d  = cfg_wdata[CNT_W-1:0];
        A_DTCODE: code_d = cfg_wdata[7:0];
        A_OUTEN:  en_d   = cfg_wdata[NUM_CH-1:0];
        A_POLINV: pol_d  = cfg_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      center_q <= 1'b0;
      div_q    <= '0;
      code_q   <= '0;
      en_q     <= '0;
      pol_q    <= '0;
      arr_q    <= '0;
    end else begin
      run_q    <= run_d;
      center_q <= center_d;
      div_q    <= div_d;
      code_q   <= code_d;
      en_q     <= en_d;
      pol_q    <= pol_d;
      arr_q    <= arr_d;
    end
  end

  assign dt_cyc = dt_cycles(code_q, div_q);

  cpwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .center   (center_q),
    .arr_sh   (arr_q),
    .cnt_o    (cnt),
    .reload_o (reload)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cmp_wr;
    assign cmp_wr = cfg_we && (cfg_addr == ADDR_W'(A_CMP0 + i));

    cpwm_channel #(.CNT_W(CNT_W)) u_channel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_wr   (cmp_wr),
      .cmp_data (cfg_wdata),
      .reload   (reload),
      .cnt      (cnt),
      .ref_o    (ref_w[i])
    );

    cpwm_deadtime #(.DT_W(DT_W)) u_deadtime (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_i    (ref_w[i]),
      .dt_cyc   (dt_cyc),
      .en       (en_q[i]),
      .pol      (pol_q[i]),
      .pin_main (pwm_main[i]),
      .pin_comp (pwm_comp[i])
    );
  end

endmodule

// File: tb/cpwm_deadband_bench.sv
`timescale 1ns/1ps
module cpwm_deadband_bench;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 8;
  localparam int CMP_W  = CNT_W + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [3:0]        cfg_addr;
  logic [CMP_W-1:0]  cfg_wdata;
  logic [NUM_CH-1:0] pwm_main, pwm_comp;

  always #2.5 clk = ~clk;

  cpwm_deadband #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_cpwm_deadband (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pwm_main(pwm_main), .pwm_comp(pwm_comp)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_run, m_center, m_div, m_code, m_en, m_pol, m_arr_sh, m_arr, m_cnt, m_up;
  int m_ccr_sh[NUM_CH], m_ccr[NUM_CH], m_refd[NUM_CH], m_tmr[NUM_CH];

  function automatic int dt_model(int code, int div);
    int units, scale, mul;
    if (code < 128)      begin units = code;             scale = 1;  end
    else if (code < 192) begin units = code - 128 + 64;  scale = 2;  end
    else if (code < 224) begin units = code - 192 + 32;  scale = 8;  end
    else                 begin units = code - 224 + 32;  scale = 16; end
    mul = (div == 0) ? 1 : ((div == 1) ? 2 : 4);
    return units * scale * mul;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_center = 0; m_div = 0; m_code = 0; m_en = 0; m_pol = 0;
      m_arr_sh = 0; m_arr = 0; m_cnt = 0; m_up = 1;
      for (int c = 0; c < NUM_CH; c++) begin
        m_ccr_sh[c] = 0; m_ccr[c] = 0; m_refd[c] = 0; m_tmr[c] = 0;
      end
    end else begin
      int dt, nref, nxt;
      bit upd;
      cyc++;
      dt = dt_model(m_code, m_div);
      for (int c = 0; c < NUM_CH; c++) begin
        nref = (m_cnt < m_ccr[c]) ? 1 : 0;
        if (nref != m_refd[c]) m_tmr[c] = dt;
        else if (m_tmr[c] > 0) m_tmr[c] = m_tmr[c] - 1;
        m_refd[c] = nref;
      end
      upd = 0;
      if (m_run == 0) begin
        m_cnt = 0; m_up = 1; upd = 1;
      end else if (m_center == 0) begin
        m_up = 1;
        if (m_cnt >= m_arr) begin m_cnt = 0; upd = 1; end
        else m_cnt = m_cnt + 1;
      end else if (m_up == 1 && m_cnt < m_arr) begin
        m_cnt = m_cnt + 1;
      end else begin
        nxt = (m_cnt > 0) ? m_cnt - 1 : 0;
        m_up = (nxt == 0) ? 1 : 0;
        upd = (nxt == 0);
        m_cnt = nxt;
      end
      if (upd) begin
        m_arr = m_arr_sh;
        for (int c = 0; c < NUM_CH; c++) m_ccr[c] = m_ccr_sh[c];
      end
      if (cfg_we) begin
        if (cfg_addr == 4'h0) begin
          m_run = int'(cfg_wdata[0]); m_center = int'(cfg_wdata[1]); m_div = int'(cfg_wdata[3:2]);
        end else if (cfg_addr == 4'h1) m_arr_sh = int'(cfg_wdata[CNT_W-1:0]);
        else if (cfg_addr == 4'h2) m_code = int'(cfg_wdata[7:0]);
        else if (cfg_addr == 4'h3) m_en = int'(cfg_wdata[NUM_CH-1:0]);
        else if (cfg_addr == 4'h4) m_pol = int'(cfg_wdata[NUM_CH-1:0]);
        else if (cfg_addr >= 4'h8 && int'(cfg_addr) < 8 + NUM_CH)
          m_ccr_sh[int'(cfg_addr) - 8] = int'(cfg_wdata);
      end
    end
  end

  task automatic chk();
    logic [NUM_CH-1:0] em, ec;
    for (int c = 0; c < NUM_CH; c++) begin
      bit settled, e, p;
      settled = (m_tmr[c] == 0);
      e = m_en[c];
      p = m_pol[c];
      em[c] = (e & (m_refd[c] == 1) & settled) ^ p;
      ec[c] = (e & (m_refd[c] == 0) & settled) ^ p;
    end
    n_vec++;
    if (pwm_main !== em || pwm_comp !== ec) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got main=%b comp=%b expected main=%b comp=%b",
               cur_req, cyc, pwm_main, pwm_comp, em, ec);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk();
  endtask

  task automatic run_n(int n);
    repeat (n) step();
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = CMP_W'(d);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_cmp(int c0, int c1, int c2, int c3);
    wr(8, c0); wr(9, c1); wr(10, c2); wr(11, c3);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got hung expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the pins
    n_vec++;
    if (pwm_main !== '0 || pwm_comp !== '0) begin
      n_bad++;
      $display("FAIL R1: got main=%b comp=%b expected main=0000 comp=0000", pwm_main, pwm_comp);
    end
    cur_req = "R1"; run_n(5);

    // R2 edge-aligned counting and PWM mode
    cur_req = "R2";
    wr(1, 9); set_cmp(3, 0, 10, 7); wr(3, 15); wr(4, 0); wr(2, 0); wr(0, 1);
    run_n(40);
    // R3 duty end points: 0 and above the period
    cur_req = "R3";
    wr(10, 200); wr(9, 0);
    run_n(30);
    // R4 shadowed period and threshold writes
    cur_req = "R4";
    run_n(3); wr(8, 6); run_n(2); wr(1, 4); run_n(40);
    wr(0, 0); wr(8, 2); run_n(5); wr(0, 1); run_n(20);
    // R6 dead band on both edges
    cur_req = "R6";
    wr(1, 19); set_cmp(5, 10, 15, 0); wr(2, 3); run_n(100);
    wr(2, 0); run_n(40);
    // R7 code ranges and division
    cur_req = "R7";
    wr(1, 255); set_cmp(40, 128, 200, 250);
    wr(0, 1); wr(2, 8'h7F); run_n(600);
    wr(2, 8'h85); run_n(600);
    wr(2, 8'h10); wr(0, 1 | (1 << 2)); run_n(600);
    wr(0, 1 | (2 << 2)); run_n(600);
    wr(0, 1 | (3 << 2)); run_n(600);
    wr(0, 1); wr(2, 8'hC1); run_n(600);
    // R8 intervals shorter than the band, 110 vs 111 ranges
    cur_req = "R8";
    wr(2, 8'hC0); wr(0, 3); set_cmp(250, 10, 128, 255); run_n(1100);
    wr(2, 8'hE0); run_n(1100);
    wr(0, 0); wr(1, 9); set_cmp(1, 8, 4, 5); wr(2, 4); wr(0, 1); run_n(60);
    // R5 center-aligned counting
    cur_req = "R5";
    wr(0, 0); wr(1, 5); set_cmp(0, 2, 6, 3); wr(2, 1); wr(0, 3); run_n(60);
    wr(1, 1); set_cmp(1, 0, 2, 1); run_n(30);
    // R9 polarity
    cur_req = "R9";
    wr(0, 0); wr(1, 9); set_cmp(3, 5, 7, 9); wr(2, 2); wr(0, 1);
    wr(4, 5); run_n(40); wr(4, 15); run_n(25);
    // R10 per-channel enable
    cur_req = "R10";
    wr(3, 3); run_n(40); wr(3, 0); run_n(15); wr(4, 0); run_n(10); wr(3, 12); run_n(30);
    summary();
  end

endmodule